// File: doc/BRIEF.md
# Sound Command Mailbox for a Two-Processor Audio Board

This block carries commands from a host to a pair of sound processors. The host offers a 10-bit command word on a valid/ready port. The low byte goes into a command register that the master processor reads. The two upper bits are active-low interrupt controls. Bit 9 at 0 raises the master's maskable interrupt and marks a command as pending. Bit 8 drives the master's non-maskable interrupt as a level.

When the master reads its command port, it receives the byte and acknowledges its interrupt. The master can pass a byte on to the slave by writing to a forwarding port. That write raises the slave's fast interrupt, and the slave's read of its own command port acknowledges it.

A host halt input holds both processors in reset and clears every interrupt.

The command port never applies back-pressure. `cmd_ready` is tied high, and every cycle with `cmd_valid` high transfers one word. Decoded ports ignore address bits 9:0, so each port answers across a 1 KiB window. The master command port sits at window base 0x3400 (addr[15:10] = 6'b001101). The forwarding port sits at 0x2C00 (addr[15:10] = 6'b001011). The slave command port sits at 0x3400.

Top module: `snd_cmd_mailbox`

## Requirements
- R1: A transfer (`cmd_valid` high) loads `cmd_data[7:0]` into `mcmd_byte`, visible one cycle after the edge. Both byte registers are 0x00 after `rst_n` and hold their value until they are next loaded.
- R2: On each transfer made while `host_halt` is low, `m_nmi` becomes the inverse of `cmd_data[8]` one cycle later. It holds that level until the next transfer or a halt.
- R3: A transfer with `cmd_data[9]` = 0 and `host_halt` low sets `m_irq` and `cmd_pending` one cycle later. A transfer with `cmd_data[9]` = 1 leaves both unchanged.
- R4: A master read (`m_rd` high) with addr[15:10] = 6'b001101 drives `mcmd_byte` onto `m_rdata` in the same cycle. It clears `m_irq` and `cmd_pending` one cycle later. Any other master read returns 0x00 and clears nothing.
- R5: If a transfer with `cmd_data[9]` = 0 and a master command read fall in the same cycle, `m_irq` and `cmd_pending` are 1 afterwards.
- R6: A master write (`m_wr` high) with addr[15:10] = 6'b001011 loads `m_wdata` into `scmd_byte` and sets `s_firq` one cycle later.
- R7: A slave read (`s_rd` high) with addr[15:10] = 6'b001101 drives `scmd_byte` onto `s_rdata` in the same cycle and clears `s_firq` one cycle later. If a forwarding write falls in the same cycle, `s_firq` stays 1.
- R8: One cycle after any edge with `host_halt` high, both `cpu_rst_m` and `cpu_rst_s` are high, and `m_irq`, `m_nmi`, `s_firq` and `cmd_pending` are 0. One cycle after `host_halt` is low, both reset lines are low.
- R9: While the reset outputs are high, processor reads return 0x00 and processor accesses change nothing. Host transfers still load `mcmd_byte`.
- R10: After `rst_n`, both reset outputs are 1 and every other output except `cmd_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| host_halt | input | 1 | Host request to hold both processors in reset |
| cmd_valid | input | 1 | Host command word offered |
| cmd_ready | output | 1 | Always 1; no back-pressure |
| cmd_data | input | 10 | [9] IRQ request (active low), [8] NMI level (active low), [7:0] command byte |
| m_addr | input | 16 | Master address |
| m_rd | input | 1 | Master read strobe |
| m_wr | input | 1 | Master write strobe |
| m_wdata | input | 8 | Master write data |
| m_rdata | output | 8 | Master read data (combinational) |
| s_addr | input | 16 | Slave address |
| s_rd | input | 1 | Slave read strobe |
| s_rdata | output | 8 | Slave read data (combinational) |
| mcmd_byte | output | 8 | Master command register |
| scmd_byte | output | 8 | Slave command register |
| m_irq | output | 1 | Master maskable interrupt |
| m_nmi | output | 1 | Master non-maskable interrupt |
| s_firq | output | 1 | Slave fast interrupt |
| cmd_pending | output | 1 | Host-visible status: command not yet read |
| cpu_rst_m | output | 1 | Master processor reset |
| cpu_rst_s | output | 1 | Slave processor reset |

## Verification
Every registered result is due one cycle after the rising edge that samples its stimulus:
- the byte registers;
- the master and slave interrupts;
- the pending flag;
- both processor reset lines.

Read data follows the address and strobe within the same cycle. The bench drives inputs 5 ns after each rising edge and compares every output at the falling edge against a behavioural model that it updates at the rising edge. Each result is therefore examined in exactly the cycle the requirements name. The race cases of R5 and R7, and the ignored accesses of R9, are checked through the outputs in the cycle after the collision.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int DATA_W = 8;
  localparam int CMD_W  = DATA_W + 2;

  // Host command word: control bits above the payload byte
  typedef struct packed {
    logic              irq_off;   // 0 requests the master IRQ
    logic              nmi_off;   // 0 holds the master NMI asserted
    logic [DATA_W-1:0] payload;
  } host_word_t;
endpackage

// File: rtl/smb_port_match.sv
module smb_port_match #(
  parameter int          ADDR_W   = 16,
  parameter int          MIRROR_W = 10,
  parameter logic [15:0] BASE     = 16'h3400
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe,
  input  logic              enable,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] LOW_MASK  = ADDR_W'((1 << MIRROR_W) - 1);
  localparam logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(BASE) & ~LOW_MASK;

  assign hit = strobe && enable && ((addr & ~LOW_MASK) == BASE_ADDR);
endmodule

// File: rtl/smb_byte_latch.sv
module smb_byte_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q)) else $error("latch changed without load"); // R1
endmodule

// File: rtl/smb_master_irq.sv
module smb_master_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  input  logic take,
  input  logic irq_req,
  input  logic nmi_lvl,
  input  logic ack,
  output logic irq,
  output logic nmi,
  output logic pending
);
  logic raise;
  assign raise = take && irq_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0; nmi <= 1'b0; pending <= 1'b0;
    end else if (halt) begin
      irq <= 1'b0; nmi <= 1'b0; pending <= 1'b0;
    end else begin
      if (take) nmi <= nmi_lvl;
      if (raise) begin
        irq <= 1'b1; pending <= 1'b1;
      end else if (ack) begin
        irq <= 1'b0; pending <= 1'b0;
      end
    end
  end

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && irq_req && !halt) |=> (irq && pending)) else $error("irq not raised"); // R3
  AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !(take && irq_req) && !halt) |=> (!irq && !pending)) else $error("ack ignored"); // R4
  AST_IRQ_RACE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && take && irq_req && !halt) |=> irq) else $error("race lost irq"); // R5
  AST_NMI_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !halt) |=> (nmi == $past(nmi_lvl))) else $error("nmi level"); // R2
  AST_HALT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!irq && !nmi && !pending)) else $error("halt left irq"); // R8
endmodule

// File: rtl/smb_slave_flag.sv
module smb_slave_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (halt)   flag <= 1'b0;
    else if (set)    flag <= 1'b1;
    else if (clr)    flag <= 1'b0;
  end

  AST_FIRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (set && !halt) |=> flag) else $error("firq not set"); // R6
  AST_FIRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set && !halt) |=> !flag) else $error("firq not cleared"); // R7
endmodule

// File: rtl/snd_cmd_mailbox.sv
module snd_cmd_mailbox
  import smb_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          MIRROR_W    = 10,
  parameter logic [15:0] CMD_RD_BASE = 16'h3400,
  parameter logic [15:0] FWD_WR_BASE = 16'h2C00,
  parameter logic [15:0] SLV_RD_BASE = 16'h3400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_halt,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic              m_rd,
  input  logic              m_wr,
  input  logic [DATA_W-1:0] m_wdata,
  output logic [DATA_W-1:0] m_rdata,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic              s_rd,
  output logic [DATA_W-1:0] s_rdata,
  output logic [DATA_W-1:0] mcmd_byte,
  output logic [DATA_W-1:0] scmd_byte,
  output logic              m_irq,
  output logic              m_nmi,
  output logic              s_firq,
  output logic              cmd_pending,
  output logic              cpu_rst_m,
  output logic              cpu_rst_s
);
  host_word_t word;
  logic       take, cpu_live;
  logic       cmd_rd_hit, fwd_wr_hit, slv_rd_hit;

  assign word      = host_word_t'(cmd_data);
  assign cmd_ready = 1'b1;
  assign take      = cmd_valid && cmd_ready;

  // Processors released: both reset lines registered together
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rst_m <= 1'b1;
      cpu_rst_s <= 1'b1;
    end else begin
      cpu_rst_m <= host_halt;
      cpu_rst_s <= host_halt;
    end
  end
  assign cpu_live = !cpu_rst_m;

  smb_port_match #(.ADDR_W(ADDR_W), .MIRROR_W(MIRROR_W), .BASE(CMD_RD_BASE)) u_cmd_rd (
    .addr(m_addr), .strobe(m_rd), .enable(cpu_live), .hit(cmd_rd_hit));
  smb_port_match #(.ADDR_W(ADDR_W), .MIRROR_W(MIRROR_W), .BASE(FWD_WR_BASE)) u_fwd_wr (
    .addr(m_addr), .strobe(m_wr), .enable(cpu_live), .hit(fwd_wr_hit));
  smb_port_match #(.ADDR_W(ADDR_W), .MIRROR_W(MIRROR_W), .BASE(SLV_RD_BASE)) u_slv_rd (
    .addr(s_addr), .strobe(s_rd), .enable(!cpu_rst_s), .hit(slv_rd_hit));

  smb_byte_latch #(.W(DATA_W)) u_mcmd (
    .clk(clk), .rst_n(rst_n), .load(take), .din(word.payload), .q(mcmd_byte));
  smb_byte_latch #(.W(DATA_W)) u_scmd (
    .clk(clk), .rst_n(rst_n), .load(fwd_wr_hit), .din(m_wdata), .q(scmd_byte));

  smb_master_irq u_mirq (
    .clk(clk), .rst_n(rst_n), .halt(host_halt), .take(take),
    .irq_req(!word.irq_off), .nmi_lvl(!word.nmi_off), .ack(cmd_rd_hit),
    .irq(m_irq), .nmi(m_nmi), .pending(cmd_pending));

  smb_slave_flag u_sfirq (
    .clk(clk), .rst_n(rst_n), .halt(host_halt),
    .set(fwd_wr_hit), .clr(slv_rd_hit), .flag(s_firq));

  assign m_rdata = cmd_rd_hit ? mcmd_byte : '0;
  assign s_rdata = slv_rd_hit ? scmd_byte : '0;

  AST_CPU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    host_halt |=> (cpu_rst_m && cpu_rst_s)) else $error("cpu not held"); // R8
  AST_CPU_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !host_halt |=> (!cpu_rst_m && !cpu_rst_s)) else $error("cpu not released"); // R8
  AST_HALTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_m |-> (m_rdata == '0 && s_rdata == '0)) else $error("read while halted"); // R9
endmodule

// File: tb/snd_cmd_mailbox_tb.sv
module snd_cmd_mailbox_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_halt = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [9:0]  cmd_data = '0;
  logic [15:0] m_addr = '0;
  logic        m_rd = 1'b0, m_wr = 1'b0;
  logic [7:0]  m_wdata = '0;
  logic [15:0] s_addr = '0;
  logic        s_rd = 1'b0;
  logic        cmd_ready, m_irq, m_nmi, s_firq, cmd_pending, cpu_rst_m, cpu_rst_s;
  logic [7:0]  m_rdata, s_rdata, mcmd_byte, scmd_byte;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  int ml = 0, sl = 0;
  bit e_irq = 0, e_nmi = 0, e_pend = 0, e_firq = 0, e_crst = 1;

  always #10 clk = ~clk;

  snd_cmd_mailbox u_dut (
    .clk(clk), .rst_n(rst_n), .host_halt(host_halt), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_data(cmd_data), .m_addr(m_addr), .m_rd(m_rd),
    .m_wr(m_wr), .m_wdata(m_wdata), .m_rdata(m_rdata), .s_addr(s_addr),
    .s_rd(s_rd), .s_rdata(s_rdata), .mcmd_byte(mcmd_byte), .scmd_byte(scmd_byte),
    .m_irq(m_irq), .m_nmi(m_nmi), .s_firq(s_firq), .cmd_pending(cmd_pending),
    .cpu_rst_m(cpu_rst_m), .cpu_rst_s(cpu_rst_s));

  function automatic bit in_window(logic [15:0] a, int base);
    return (int'(a) / 1024) == (base / 1024);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ml = 0; sl = 0; e_irq = 0; e_nmi = 0; e_pend = 0; e_firq = 0; e_crst = 1;
    end else begin
      bit live, rd_cmd, wr_fwd, rd_slv;
      live   = !e_crst;
      rd_cmd = live && m_rd && in_window(m_addr, 'h3400);
      wr_fwd = live && m_wr && in_window(m_addr, 'h2C00);
      rd_slv = live && s_rd && in_window(s_addr, 'h3400);
      if (cmd_valid) ml = cmd_data % 256;
      if (wr_fwd) sl = m_wdata;
      if (host_halt) begin
        e_irq = 0; e_nmi = 0; e_pend = 0; e_firq = 0;
      end else begin
        if (cmd_valid) e_nmi = (cmd_data[8] == 1'b0);
        if (cmd_valid && cmd_data[9] == 1'b0) begin
          e_irq = 1; e_pend = 1;
        end else if (rd_cmd) begin
          e_irq = 0; e_pend = 0;
        end
        if (wr_fwd) e_firq = 1;
        else if (rd_slv) e_firq = 0;
      end
      e_crst = host_halt;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    bit live;
    live = !e_crst;
    chk("R1 mcmd_byte", int'(mcmd_byte), ml);
    chk("R6 scmd_byte", int'(scmd_byte), sl);
    chk("R2 m_nmi", int'(m_nmi), int'(e_nmi));
    chk("R3 m_irq", int'(m_irq), int'(e_irq));
    chk("R3 cmd_pending", int'(cmd_pending), int'(e_pend));
    chk("R7 s_firq", int'(s_firq), int'(e_firq));
    chk("R8 cpu_rst_m", int'(cpu_rst_m), int'(e_crst));
    chk("R8 cpu_rst_s", int'(cpu_rst_s), int'(e_crst));
    chk("R4 m_rdata", int'(m_rdata),
        (live && m_rd && in_window(m_addr, 'h3400)) ? ml : 0);
    chk("R7 s_rdata", int'(s_rdata),
        (live && s_rd && in_window(s_addr, 'h3400)) ? sl : 0);
    chk("R10 cmd_ready", int'(cmd_ready), 1);
  end

  // one cycle of stimulus, starting 5 ns after a rising edge
  task automatic go(bit cv, logic [9:0] cd, bit mr, bit mw, logic [15:0] ma,
                    logic [7:0] md, bit sr, logic [15:0] sa);
    cmd_valid = cv; cmd_data = cd; m_rd = mr; m_wr = mw; m_addr = ma;
    m_wdata = md; s_rd = sr; s_addr = sa;
    @(posedge clk); #5;
    cmd_valid = 0; m_rd = 0; m_wr = 0; s_rd = 0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #5; end
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;                                   // R10 reset state seen above
    idle(2);
    // R1 R2 R3: several host words
    go(1, 10'h0A5, 0, 0, 0, 0, 0, 0);               // irq + nmi
    go(1, 10'h3C3, 0, 0, 0, 0, 0, 0);               // neither: nmi released, irq kept
    go(1, 10'h13C, 0, 0, 0, 0, 0, 0);               // irq, nmi released
    go(1, 10'h25A, 0, 0, 0, 0, 0, 0);               // nmi only
    idle(1);
    // R4: non-matching read, mirrored read, base read
    go(0, 0, 1, 0, 16'h3800, 0, 0, 0);
    go(0, 0, 1, 0, 16'h37FF, 0, 0, 0);
    go(1, 10'h011, 0, 0, 0, 0, 0, 0);
    go(0, 0, 1, 0, 16'h3400, 0, 0, 0);
    // R5: raise and ack in the same cycle
    go(1, 10'h177, 1, 0, 16'h3400, 0, 0, 0);
    go(1, 10'h388, 1, 0, 16'h3400, 0, 0, 0);        // ack without raise clears
    // R6 R7: forwarding to the slave
    go(0, 0, 0, 1, 16'h2C00, 8'h5E, 0, 0);
    go(0, 0, 0, 0, 0, 0, 1, 16'h3000);              // outside window
    go(0, 0, 0, 0, 0, 0, 1, 16'h35AA);
    go(0, 0, 0, 1, 16'h2FFF, 8'hC1, 1, 16'h3400);   // R7 race: set wins
    go(0, 0, 0, 1, 16'h3000, 8'h99, 1, 16'h3400);   // wrong write port
    // R8 R9: halt with everything raised
    go(1, 10'h042, 0, 1, 16'h2C00, 8'h33, 0, 0);
    host_halt = 1'b1;
    idle(1);
    go(0, 0, 1, 1, 16'h2C00, 8'hEE, 0, 0);          // R9 ignored
    go(0, 0, 1, 0, 16'h3400, 0, 1, 16'h3400);       // R9 reads blank
    go(1, 10'h0F0, 0, 0, 0, 0, 0, 0);               // R9 byte loads, no irq
    host_halt = 1'b0;
    idle(1);
    go(0, 0, 1, 0, 16'h3400, 0, 0, 0);
    go(1, 10'h2AB, 0, 0, 0, 0, 0, 0);
    idle(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule